// File: doc/BRIEF.md
# Receive Margin Control Write Sequencer

This block sits between a lane-margining command processor and the PHY register write port. It accepts one margining request at a time over a valid/ready handshake: stop margining, clear the error log, step the timing offset, or step the voltage offset. Each request becomes a short series of register writes to two receive margin control registers. Control register 1 holds the margin offset. Control register 0 holds the start, mode, error-reset, direction and lane fields.

A step request writes the offset to control register 1 as an uncommitted write. A committed write to control register 0 follows on the next cycle. Stop and clear requests change a single field of control register 0. The block keeps a mirror of the last committed control register 0 value, and the remaining fields of those two requests come from that mirror.

After the committed write the sequencer waits for the PHY write acknowledge. Except on a clear request, it then waits for the PHY to write back a committed margin status. Each wait has its own timeout of `TIMEOUT_CYCLES` clock cycles. An expired wait raises a sticky flag and lets the request complete. A one-cycle `done` pulse ends every request.

Top module: `margin_wr_seq`

## Requirements
- R1: After reset `reqReady` is 1, `wrValid`, `done`, `ackSeen`, `ackTimeout` and `statusTimeout` are 0, and the control register 0 mirror is 0x00.
- R2: Request op codes: 0 = stop, 1 = clear error log, 2 = timing step, 3 = voltage step. For a step request, the cycle after acceptance carries an uncommitted write (`wrAddr`=1, `wrCommit`=0). The next cycle carries a committed write to control register 0 (`wrAddr`=0, `wrCommit`=1). Stop and clear requests issue only the committed write, in the cycle after acceptance.
- R3: The control register 1 data is {2'b00, offset[5:0]} for a timing step and {1'b0, offset[6:0]} for a voltage step.
- R4: Control register 0 layout: bit 0 start, bit 1 timing mode, bit 2 voltage mode, bit 3 error-count reset, bit 4 direction, bits 7:5 lane. A timing step writes start=1, timing=1, voltage=0, reset=0, with the direction and lane from the request. A voltage step writes the same but with timing=0 and voltage=1.
- R5: A stop request writes the mirror value with bit 0 cleared. A clear request writes the mirror value with bit 3 set.
- R6: The mirror takes the value of every committed control register 0 write.
- R7: Acknowledge wait: if `phyWrAck` is high on the k-th cycle of the wait, with k counted from 0 and k < TIMEOUT_CYCLES, the wait ends after k+1 cycles and `ackSeen` is set. Otherwise it ends after TIMEOUT_CYCLES cycles and sets the sticky `ackTimeout`. `ackSeen` is cleared when a request is accepted.
- R8: The status wait ends the same way on `phyStatusWr`, or on timeout with a sticky `statusTimeout`. `done` is high for one cycle, right after the last wait, and `reqReady` returns the cycle after that.
- R9: From acceptance until the cycle after `done`, `reqReady` is 0.
- R10: A clear request skips the status wait: `done` follows the acknowledge wait directly.
- R11: A `phyWrAck` pulse outside the acknowledge wait, for example during the committed write cycle, has no effect on the wait or on `ackSeen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer idle, request accepted when valid |
| reqOp | input | 2 | Request op code |
| reqOffset | input | 7 | Margin offset for step requests |
| reqDir | input | 1 | Step direction |
| reqLane | input | 3 | Target lane for step requests |
| wrValid | output | 1 | Register write strobe to the PHY |
| wrAddr | output | 1 | 0 = control register 0, 1 = control register 1 |
| wrCommit | output | 1 | Write is committed |
| wrData | output | 8 | Register write data |
| phyWrAck | input | 1 | PHY write acknowledge pulse |
| phyStatusWr | input | 1 | PHY committed status write-back pulse |
| done | output | 1 | One-cycle request completion pulse |
| ackSeen | output | 1 | Acknowledge arrived for the last request |
| ackTimeout | output | 1 | Sticky: an acknowledge wait timed out |
| statusTimeout | output | 1 | Sticky: a status wait timed out |

## Verification
The bench builds the sequencer with `TIMEOUT_CYCLES` set to 12 instead of the real-time default. This brings both the acknowledge and the status timeout within a few cycles. Random response delays then fall both inside and beyond the window, so exact completion cycles can be checked for every delay, including the last cycle before expiry. The short window also lets a long random run of mixed stop, clear and step requests exercise the mirror merge many times.

// File: rtl/margin_seq_pkg.sv
package margin_seq_pkg;

  typedef enum logic [1:0] {
    OP_STOP   = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_TIMING = 2'd2,
    OP_VOLT   = 2'd3
  } opKind_e;

  // control register 0 field positions
  localparam int C0_START = 0;
  localparam int C0_TIM   = 1;
  localparam int C0_VOL   = 2;
  localparam int C0_ERST  = 3;
  localparam int C0_DIR   = 4;
  localparam int C0_LANE  = 5;
  localparam int LANE_W   = 3;
  localparam int REG_W    = 8;
  localparam int OFS_W    = 7;

  typedef struct packed {
    logic latchReq;
    logic issueCtl1;
    logic issueCtl0;
    logic clrAckSeen;
    logic setAckSeen;
    logic setAckTo;
    logic setStatTo;
  } seqStrobe_t;

endpackage

// File: rtl/msq_ctrl.sv
module msq_ctrl
  import margin_seq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  opKind_e    reqOp,
  input  logic       phyWrAck,
  input  logic       phyStatusWr,
  output logic       reqReady,
  output logic       done,
  output seqStrobe_t strobe
);

  localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WR1, S_WR0, S_ACK, S_STAT, S_DONE
  } seqState_e;

  seqState_e state, nextState;
  logic [CW-1:0] waitCnt;
  logic skipStat;
  logic accept;
  logic cntExpired;

  assign reqReady   = (state == S_IDLE);
  assign done       = (state == S_DONE);
  assign accept     = reqValid && reqReady;
  assign cntExpired = (waitCnt == LAST);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          strobe.latchReq   = 1'b1;
          strobe.clrAckSeen = 1'b1;
          nextState = (reqOp == OP_TIMING || reqOp == OP_VOLT) ? S_WR1 : S_WR0;
        end
      end
      S_WR1: begin
        strobe.issueCtl1 = 1'b1;
        nextState = S_WR0;
      end
      S_WR0: begin
        strobe.issueCtl0 = 1'b1;
        nextState = S_ACK;
      end
      S_ACK: begin
        if (phyWrAck) begin
          strobe.setAckSeen = 1'b1;
          nextState = skipStat ? S_DONE : S_STAT;
        end else if (cntExpired) begin
          strobe.setAckTo = 1'b1;
          nextState = skipStat ? S_DONE : S_STAT;
        end
      end
      S_STAT: begin
        if (phyStatusWr) begin
          nextState = S_DONE;
        end else if (cntExpired) begin
          strobe.setStatTo = 1'b1;
          nextState = S_DONE;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      skipStat <= 1'b0;
      waitCnt  <= '0;
    end else begin
      state <= nextState;
      if (accept) skipStat <= (reqOp == OP_CLEAR);
      if (nextState != state) waitCnt <= '0;
      else if (state == S_ACK || state == S_STAT) waitCnt <= waitCnt + 1'b1;
    end
  end

  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= LAST);

endmodule

// File: rtl/msq_dp.sv
module msq_dp
  import margin_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  opKind_e           reqOp,
  input  logic [OFS_W-1:0]  reqOffset,
  input  logic              reqDir,
  input  logic [LANE_W-1:0] reqLane,
  output logic              wrValid,
  output logic              wrAddr,
  output logic              wrCommit,
  output logic [REG_W-1:0]  wrData,
  output logic              ackSeen,
  output logic              ackTimeout,
  output logic              statusTimeout
);

  opKind_e           opQ;
  logic [OFS_W-1:0]  offsetQ;
  logic              dirQ;
  logic [LANE_W-1:0] laneQ;
  logic [REG_W-1:0]  mirror;
  logic [REG_W-1:0]  ctl0Data;
  logic [REG_W-1:0]  ctl1Data;

  always_comb begin
    ctl0Data = mirror;
    unique case (opQ)
      OP_STOP:  ctl0Data[C0_START] = 1'b0;
      OP_CLEAR: ctl0Data[C0_ERST]  = 1'b1;
      OP_TIMING, OP_VOLT: begin
        ctl0Data = '0;
        ctl0Data[C0_START] = 1'b1;
        ctl0Data[C0_TIM]   = (opQ == OP_TIMING);
        ctl0Data[C0_VOL]   = (opQ == OP_VOLT);
        ctl0Data[C0_DIR]   = dirQ;
        ctl0Data[C0_LANE +: LANE_W] = laneQ;
      end
      default: ctl0Data = mirror;
    endcase
  end

  always_comb begin
    if (opQ == OP_TIMING) ctl1Data = {2'b00, offsetQ[5:0]};
    else                  ctl1Data = {1'b0, offsetQ};
  end

  assign wrValid  = strobe.issueCtl0 || strobe.issueCtl1;
  assign wrAddr   = strobe.issueCtl1;
  assign wrCommit = strobe.issueCtl0;
  assign wrData   = strobe.issueCtl1 ? ctl1Data : (strobe.issueCtl0 ? ctl0Data : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ           <= OP_STOP;
      offsetQ       <= '0;
      dirQ          <= 1'b0;
      laneQ         <= '0;
      mirror        <= '0;
      ackSeen       <= 1'b0;
      ackTimeout    <= 1'b0;
      statusTimeout <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        opQ     <= reqOp;
        offsetQ <= reqOffset;
        dirQ    <= reqDir;
        laneQ   <= reqLane;
      end
      if (strobe.issueCtl0) mirror <= ctl0Data;
      if (strobe.clrAckSeen)      ackSeen <= 1'b0;
      else if (strobe.setAckSeen) ackSeen <= 1'b1;
      if (strobe.setAckTo)  ackTimeout    <= 1'b1;
      if (strobe.setStatTo) statusTimeout <= 1'b1;
    end
  end

  // R2
  ctl1_then_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrCommit) |=> (wrValid && wrCommit && !wrAddr));

  // R6
  mirror_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrCommit) |=> (mirror == $past(wrData)));

  // R7
  ack_to_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackTimeout |=> ackTimeout);

  // R8
  stat_to_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusTimeout |=> statusTimeout);

endmodule

// File: rtl/margin_wr_seq.sv
module margin_wr_seq
  import margin_seq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] reqOp,
  input  logic [6:0] reqOffset,
  input  logic       reqDir,
  input  logic [2:0] reqLane,
  output logic       wrValid,
  output logic       wrAddr,
  output logic       wrCommit,
  output logic [7:0] wrData,
  input  logic       phyWrAck,
  input  logic       phyStatusWr,
  output logic       done,
  output logic       ackSeen,
  output logic       ackTimeout,
  output logic       statusTimeout
);

  seqStrobe_t strobe;
  opKind_e    opIn;

  assign opIn = opKind_e'(reqOp);

  msq_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opIn),
    .phyWrAck(phyWrAck), .phyStatusWr(phyStatusWr),
    .reqReady(reqReady), .done(done), .strobe(strobe)
  );

  msq_dp dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(opIn),
    .reqOffset(reqOffset), .reqDir(reqDir), .reqLane(reqLane),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrCommit(wrCommit), .wrData(wrData),
    .ackSeen(ackSeen), .ackTimeout(ackTimeout), .statusTimeout(statusTimeout)
  );

endmodule

// File: tb/margin_wr_seq_test.sv
module margin_wr_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TO = 12;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = 2'd0;
  logic [6:0] reqOffset = '0;
  logic reqDir = 1'b0;
  logic [2:0] reqLane = '0;
  logic wrValid, wrAddr, wrCommit;
  logic [7:0] wrData;
  logic phyWrAck = 1'b0;
  logic phyStatusWr = 1'b0;
  logic done, ackSeen, ackTimeout, statusTimeout;

  int total = 0;
  int bad = 0;
  logic [7:0] expMirror = 8'h00;
  bit expAckTo = 1'b0;
  bit expStatTo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  margin_wr_seq #(.TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqOffset(reqOffset), .reqDir(reqDir), .reqLane(reqLane),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrCommit(wrCommit), .wrData(wrData),
    .phyWrAck(phyWrAck), .phyStatusWr(phyStatusWr), .done(done),
    .ackSeen(ackSeen), .ackTimeout(ackTimeout), .statusTimeout(statusTimeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expCtl1(input logic [1:0] op, input logic [6:0] ofs);
    return (op == 2'd2) ? {2'b00, ofs[5:0]} : {1'b0, ofs};
  endfunction

  function automatic logic [7:0] expCtl0(input logic [1:0] op, input logic [7:0] mir,
                                         input logic dir, input logic [2:0] lane);
    logic [7:0] d;
    d = mir;
    case (op)
      2'd0: d[0] = 1'b0;
      2'd1: d[3] = 1'b1;
      default: d = {lane, dir, 1'b0, (op == 2'd3), (op == 2'd2), 1'b1};
    endcase
    return d;
  endfunction

  function automatic int phaseLen(input int delay);
    return (delay < TO) ? delay + 1 : TO;
  endfunction

  // a / s: cycle index in the acknowledge / status wait at which the PHY
  // answers (NEVER for no answer); spur drives a stray ack in the write cycle
  task automatic runReq(input logic [1:0] op, input logic [6:0] ofs, input logic dir,
                        input logic [2:0] lane, input int a, input int s, input bit spur);
    logic [7:0] c0;
    int ackLen, expN, doneAt;
    bit isStep, isClear;
    isStep  = (op >= 2'd2);
    isClear = (op == 2'd1);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqOffset = ofs; reqDir = dir; reqLane = lane;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R9 busy after accept", reqReady, 0);
    if (isStep) begin
      chk(wrValid && wrAddr && !wrCommit, "R2 uncommitted ctl1 write",
          {wrValid, wrAddr, wrCommit}, 3'b110);
      chk(wrData == expCtl1(op, ofs), "R3 ctl1 data", wrData, expCtl1(op, ofs));
      @(negedge clk);
    end
    c0 = expCtl0(op, expMirror, dir, lane);
    chk(wrValid && !wrAddr && wrCommit, "R2 committed ctl0 write",
        {wrValid, wrAddr, wrCommit}, 3'b101);
    chk(wrData == c0, isStep ? "R4 ctl0 step data" : "R5 ctl0 mirror merge data",
        wrData, c0);
    expMirror = c0;
    if (spur) phyWrAck = 1'b1;
    ackLen = phaseLen(a);
    expN = isClear ? ackLen : ackLen + phaseLen(s);
    doneAt = -1;
    for (int n = 0; n < 4 * TO; n++) begin
      @(negedge clk);
      phyWrAck    = (n == a);
      phyStatusWr = !isClear && (n == ackLen + s);
      if (done) begin
        doneAt = n;
        break;
      end
    end
    phyWrAck = 1'b0;
    phyStatusWr = 1'b0;
    if (a >= TO) expAckTo = 1'b1;
    if (!isClear && s >= TO) expStatTo = 1'b1;
    chk(doneAt == expN, isClear ? "R10 done after ack wait" : "R8 done cycle",
        doneAt, expN);
    chk(ackSeen == (a < TO), spur ? "R11 stray ack ignored" : "R7 ackSeen",
        ackSeen, (a < TO));
    chk(ackTimeout == expAckTo, "R7 ackTimeout", ackTimeout, expAckTo);
    chk(statusTimeout == expStatTo, "R8 statusTimeout", statusTimeout, expStatTo);
    @(negedge clk);
    chk(reqReady && !done, "R8 ready after done", {reqReady, done}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(reqReady && !wrValid && !done, "R1 reset outputs",
        {reqReady, wrValid, done}, 3'b100);
    chk(!ackSeen && !ackTimeout && !statusTimeout, "R1 reset flags",
        {ackSeen, ackTimeout, statusTimeout}, 0);
    rstN = 1'b1;
    // R1: stop straight after reset writes the zero mirror
    runReq(2'd0, 7'h00, 1'b0, 3'd0, 0, 0, 1'b0);
    // R3 R4: timing step with offset bit 6 set, masked off
    runReq(2'd2, 7'h7F, 1'b1, 3'd5, 2, 3, 1'b0);
    // R5: stop keeps lane/dir/mode from mirror
    runReq(2'd0, 7'h11, 1'b0, 3'd0, 0, 1, 1'b0);
    // R3 R4: voltage step
    runReq(2'd3, 7'h45, 1'b0, 3'd2, TO - 1, TO - 1, 1'b0);
    // R10 R5: clear, ack in time
    runReq(2'd1, 7'h00, 1'b0, 3'd0, 4, 0, 1'b0);
    // R11: stray ack in the write cycle, no real ack -> timeout
    runReq(2'd2, 7'h21, 1'b0, 3'd1, NEVER, 2, 1'b1);
    // R8: status timeout
    runReq(2'd3, 7'h09, 1'b1, 3'd7, 1, NEVER, 1'b0);
    // R10: clear with ack timeout
    runReq(2'd1, 7'h00, 1'b0, 3'd0, NEVER, 0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      int a, s;
      a = int'($urandom % (TO + 4));
      s = int'($urandom % (TO + 4));
      if (a >= TO) a = NEVER;
      if (s >= TO) s = NEVER;
      runReq(2'($urandom), 7'($urandom), 1'($urandom), 3'($urandom), a, s, 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule